// File: doc/BRIEF.md
# Numerically Controlled Waveform Oscillator

This block is a numerically controlled oscillator for a digital waveform source. On every clock it adds a frequency word to a 28-bit phase register that wraps modulo 2^28. The output frequency is therefore `tune × f_clk / 2^28`. The upper 12 bits of the phase register are taken and the lower bits are dropped. A 12-bit phase shift is added to them modulo 4096. The result drives one of three shapers, picked by a 2-bit select: a sine, a triangle or a square. All three produce a 10-bit offset-binary sample with a valid flag.

The sine shaper holds only one quarter of a cycle as a table of magnitudes. The table is computed when the design is elaborated. The second quarter reads the table backwards by inverting its address. The second half inverts the sample about mid-scale. A new frequency word is added from the next clock edge on, so the phase never jumps. The asynchronous reset returns the phase to zero. Several instances that share a clock and a reset release therefore run phase-coherent. Their relative phases are then set through the phase-shift input.

Top module: `dds_core`

## Requirements
- R1: While reset is asserted, `valid_o` is 0 and `sample_o` is mid-scale, 512.
- R2: After the first clock edge that follows reset release, the phase register advances by `tune_i` modulo 2^28 on each rising edge. With tune = 2^k, the square output therefore repeats every 2^(28-k) clocks.
- R3: `valid_o` rises on the second rising edge after reset release and stays high. The first valid sample is produced from phase 0 plus the phase shift.
- R4: A new `tune_i` value is used on the next accumulation. The phase continues from its current value, with no jump and no reset of the register.
- R5: The shaped phase p (12 bits) is the phase register's bits [27:16] plus `ofs_i`, modulo 4096. It is registered one clock after the phase register. `sample_o` follows one clock after p.
- R6: With `wave_i` = 2'b00, `sample_o` is within 2 LSB of 511.5 + 511·sin(2π·(p[11:2]+0.5)/1024). Bits p[1:0] have no effect.
- R7: The sine output obeys exact symmetry. s(p) + s(p XOR 0x800) = 1023. s(p) also equals s({p[11], ~p[10:2], p[1:0]}).
- R8: With `wave_i` = 2'b01, `sample_o` is p[10:1] when p[11] = 0 and 1023 − p[10:1] when p[11] = 1.
- R9: With `wave_i` = 2'b10, `sample_o` is 1023 when p[11] = 0 and 0 when p[11] = 1.
- R10: `wave_i` = 2'b11 gives the sine output. `wave_i` is sampled on the same edge that updates `sample_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | 28 | Frequency word added to the phase each clock |
| ofs_i | input | 12 | Phase shift added to the truncated phase |
| wave_i | input | 2 | Shape select: 00 sine, 01 triangle, 10 square, 11 sine |
| sample_o | output | 10 | Offset-binary amplitude sample |
| valid_o | output | 1 | Sample valid |

## Verification
With a zero frequency word, the phase-shift input is swept over all 4096 phase codes in every shape. This isolates the shapers from the accumulator. The sine results are compared against a full-cycle table built in the bench, and against one another to expose errors in the mirroring or inversion. Power-of-two frequency words are measured by the period of the square output, which confirms the modular wrap. A long run mixes odd frequency words, a word at the Nyquist limit, mid-run word changes and a shape select that changes every clock. Any lost accumulation, phase jump or misaligned pipeline stage then shows up as a sample mismatch.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE  = 2'b00,
    WAVE_TRI   = 2'b01,
    WAVE_SQR   = 2'b10,
    WAVE_SINE2 = 2'b11
  } wave_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] tune_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  // modular wrap is implicit in the register width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + tune_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_map.sv
module dds_phase_map #(
  parameter int PH_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] acc_top_i,
  input  logic [PH_W-1:0] ofs_i,
  output logic [PH_W-1:0] phase_o,
  output logic            vld_o
);
  logic [PH_W-1:0] phase_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= acc_top_i + ofs_i;
      vld_q   <= 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int LUT_AW = 8,
  parameter int MAG_W  = 9
) (
  input  logic [LUT_AW-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);
  localparam int DEPTH = 2 ** LUT_AW;
  localparam longint AMAX = (64'sd1 <<< MAG_W) - 1;
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // sine at the centre of each bin, fixed point Q30, odd Taylor terms
  function automatic longint qsin(input int k);
    longint x, term, sum;
    x    = (HALF_PI_Q30 * longint'(2 * k + 1)) / longint'(2 * DEPTH);
    term = x;
    sum  = x;
    for (int n = 1; n <= 5; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return (sum * AMAX + (64'sd1 <<< 29)) >>> 30;
  endfunction

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam longint VAL = qsin(i);
    assign tbl[i] = MAG_W'(VAL);
  end

  assign mag_o = tbl[addr_i];
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int PH_W   = 12,
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [PH_W-1:0]  phase_i,
  input  wave_e            mode_i,
  output logic [AMP_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int MAG_W = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = {1'b1, {MAG_W{1'b0}}};

  logic              half;
  logic              mirror;
  logic [LUT_AW-1:0] raw_addr;
  logic [LUT_AW-1:0] rom_addr;
  logic [MAG_W-1:0]  mag;
  logic [AMP_W-1:0]  sine_pos;
  logic [AMP_W-1:0]  sine_val;
  logic [AMP_W-1:0]  tri_ramp;
  logic [AMP_W-1:0]  tri_val;
  logic [AMP_W-1:0]  sqr_val;
  logic [AMP_W-1:0]  shape_d;
  logic [AMP_W-1:0]  sample_q;
  logic              valid_q;
  logic              unused_lsbs;

  assign half     = phase_i[PH_W-1];
  assign mirror   = phase_i[PH_W-2];
  assign raw_addr = phase_i[PH_W-3 -: LUT_AW];
  assign rom_addr = mirror ? ~raw_addr : raw_addr;

  dds_quarter_rom #(
    .LUT_AW(LUT_AW),
    .MAG_W (MAG_W)
  ) u_rom (
    .addr_i(rom_addr),
    .mag_o (mag)
  );

  // second half mirrors about mid-scale
  assign sine_pos = {1'b1, mag};
  assign sine_val = half ? ~sine_pos : sine_pos;
  assign tri_ramp = phase_i[PH_W-2 -: AMP_W];
  assign tri_val  = half ? ~tri_ramp : tri_ramp;
  assign sqr_val  = {AMP_W{~half}};
  assign unused_lsbs = ^phase_i;

  always_comb begin
    case (mode_i)
      WAVE_TRI: shape_d = tri_val;
      WAVE_SQR: shape_d = sqr_val;
      default:  shape_d = sine_val;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= MID;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= shape_d;
      valid_q  <= vld_i;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int AMP_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] tune_i,
  input  logic [PH_W-1:0]  ofs_i,
  input  logic [1:0]       wave_i,
  output logic [AMP_W-1:0] sample_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_q;
  logic             phase_vld;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tune_i(tune_i),
    .acc_o (acc_q)
  );

  // truncation: only the top PH_W accumulator bits reach the shaper
  dds_phase_map #(.PH_W(PH_W)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_top_i(acc_q[ACC_W-1 -: PH_W]),
    .ofs_i    (ofs_i),
    .phase_o  (phase_q),
    .vld_o    (phase_vld)
  );

  dds_shaper #(
    .PH_W  (PH_W),
    .LUT_AW(LUT_AW),
    .AMP_W (AMP_W)
  ) u_shape (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (phase_vld),
    .phase_i (phase_q),
    .mode_i  (wave_e'(wave_i)),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ACC_W-1:0] tune_i,
  input logic [PH_W-1:0]  ofs_i,
  input logic [1:0]       wave_i,
  input logic [ACC_W-1:0] acc_q,
  input logic [PH_W-1:0]  phase_q,
  input logic [AMP_W-1:0] sample_o,
  input logic             valid_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_acc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> acc_q == $past(acc_q) + $past(tune_i));

  p_valid_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_phase_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> phase_q == $past(acc_q[ACC_W-1 -: PH_W]) + $past(ofs_i));

  p_square_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && valid_o && $past(wave_i) == 2'b10)
      |-> (sample_o == '0 || sample_o == '1));
endmodule

bind dds_core dds_core_chk #(
  .ACC_W(ACC_W),
  .PH_W (PH_W),
  .AMP_W(AMP_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tune_i  (tune_i),
  .ofs_i   (ofs_i),
  .wave_i  (wave_i),
  .acc_q   (acc_q),
  .phase_q (phase_q),
  .sample_o(sample_o),
  .valid_o (valid_o)
);

// File: tb/sim_dds_core.sv
module sim_dds_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] tune = '0;
  logic [11:0] ofs = '0;
  logic [1:0]  wave = 2'b00;
  logic [9:0]  sample;
  logic        valid;

  int  n_chk = 0;
  int  n_err = 0;
  real ref_sin [1024];
  int  s_tab [4096];

  always #5 clk = ~clk;

  dds_core u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tune_i  (tune),
    .ofs_i   (ofs),
    .wave_i  (wave),
    .sample_o(sample),
    .valid_o (valid)
  );

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_of(input int mode, input int p);
    int h, t;
    h = (p >> 11) & 1;
    case (mode)
      1: begin t = (p >> 1) & 1023; return h ? 1023 - t : t; end
      2: return h ? 0 : 1023;
      default: return $rtoi(ref_sin[(p >> 2) & 1023] + 0.5);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step2();
    @(negedge clk);
    @(negedge clk);
  endtask

  // R1, R3: reset values and first valid sample
  task automatic t_reset_state();
    tune = 28'h0100000; ofs = 12'h123; wave = 2'b01;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid in reset", int'(valid), 0, 0);
    chk("R1 sample in reset", int'(sample), 512, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 valid after one edge", int'(valid), 0, 0);
    @(negedge clk);
    chk("R3 valid after two edges", int'(valid), 1, 0);
    chk("R3 first sample from phase 0 plus shift", int'(sample), 145, 0);
    @(negedge clk);
    chk("R3 valid stays high", int'(valid), 1, 0);
  endtask

  // R5..R10 with a frozen accumulator: p equals the shift input
  task automatic t_sweep();
    tune = '0; wave = 2'b00; ofs = '0;
    do_reset();
    for (int p = 0; p < 4096; p++) begin
      ofs = 12'(p); wave = 2'b00;
      step2();
      s_tab[p] = int'(sample);
      chk("R6 sine vs full-cycle table", s_tab[p], exp_of(0, p), 2);
    end
    for (int p = 0; p < 4096; p++) begin
      int pm;
      pm = (p & 12'h803) | ((~p) & 12'h7FC);
      chk("R7 half-wave antisymmetry", s_tab[p] + s_tab[p ^ 12'h800], 1023, 0);
      chk("R7 quarter mirror", s_tab[p], s_tab[pm], 0);
      chk("R6 low phase bits ignored", s_tab[p], s_tab[p & 12'hFFC], 0);
    end
    for (int p = 0; p < 4096; p++) begin
      ofs = 12'(p); wave = 2'b01;
      step2();
      chk("R8 triangle", int'(sample), exp_of(1, p), 0);
    end
    for (int p = 0; p < 4096; p += 4) begin
      ofs = 12'(p); wave = 2'b10;
      step2();
      chk("R9 square", int'(sample), exp_of(2, p), 0);
    end
    for (int p = 0; p < 4096; p += 64) begin
      ofs = 12'(p + 5); wave = 2'b11;
      step2();
      chk("R10 select 11 gives sine", int'(sample), s_tab[p + 5], 0);
    end
  endtask

  // R2: square period for power-of-two words
  task automatic t_wrap(input int k);
    int prev, cnt, rises;
    tune = 28'(1 << k); ofs = '0; wave = 2'b10;
    do_reset();
    step2();
    prev = sample[9]; cnt = 0; rises = 0;
    while (rises < 2 && cnt < 5000) begin
      @(negedge clk);
      if (rises == 1) cnt++;
      if (sample[9] && !prev) rises++;
      if (rises == 0) cnt = 0;
      prev = sample[9];
    end
    chk("R2 square repeat period", cnt, 1 << (28 - k), 0);
  endtask

  // R2, R4, R10: running accumulator, word changes, per-cycle shape change
  task automatic t_stream(input logic [27:0] m1, input logic [27:0] m2,
                          input int sw, input int n, input logic [11:0] sh);
    int unsigned acc_m, acc_n;
    int p_m, p_n, e_mode, e_p;
    bit v1, v2;
    tune = m1; ofs = sh; wave = 2'b00;
    do_reset();
    acc_m = 0; p_m = 0; v1 = 0; v2 = 0; e_mode = 0; e_p = 0;
    for (int i = 0; i < n; i++) begin
      tune = (i < sw) ? m1 : m2;
      wave = 2'(i * 7 % 4);
      acc_n = (acc_m + 32'(tune)) & 32'h0FFFFFFF;
      p_n   = int'(((acc_m >> 16) + 32'(sh)) & 32'hFFF);
      e_mode = int'(wave); e_p = p_m;
      v2 = v1; v1 = 1;
      @(negedge clk);
      acc_m = acc_n; p_m = p_n;
      if (v2) begin
        if (i < sw + 3) chk("R2 running phase", int'(sample), exp_of(e_mode, e_p), 2);
        else            chk("R4 continuous after word change", int'(sample), exp_of(e_mode, e_p), 2);
      end
    end
  endtask

  initial begin
    #1500000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int j = 0; j < 1024; j++)
      ref_sin[j] = 511.5 + 511.0 * $sin(2.0 * 3.14159265358979 * (real'(j) + 0.5) / 1024.0);
    t_reset_state();
    t_sweep();
    t_wrap(20);
    t_wrap(22);
    t_wrap(24);
    t_stream(28'h0123457, 28'h3ABCDEF, 60, 200, 12'h3A5);
    t_stream(28'h7FFFFFF, 28'h0000001, 40, 120, 12'h000);
    t_stream(28'h00F0F0F, 28'h0543210, 100, 300, 12'hC01);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule